// File: doc/BRIEF.md
# Link power-status controller

This block watches the power-status level driven by the link-layer controller and decides, from how long that level stays low, what state the physical-to-link interface is in. A short dip is ignored. A low lasting past a first threshold puts the interface into a reset state: data and control outputs are forced to zero and link requests are ignored, while the system clock keeps running. A low lasting past a second, longer threshold disables the interface and stops the system clock as well. When the status level is seen high again, the interface goes through a fixed initialization window and then returns to normal operation.

The block also decides when the whole device may drop into a low-power mode. That happens only while the interface is disabled and every cable port is idle. It leaves low-power mode when the status level returns or a port event needs attention. A restart from low-power mode first waits out a clock-settling window, and this window is bounded so that the system clock is running again within a fixed deadline. A cable-not-active flag reports, without filtering, that no port sees incoming bias. All timers count cycles of an always-on reference clock. The thresholds are parameters: the defaults match 2.6 ms and 26 ms at 24.576 MHz.

Top module: `lps_if_ctrl`

## Requirements
- R1: `link_pwr` is sampled on each clock edge and a counter holds the number of consecutive low samples. From NORMAL (if_state 4) or INIT (2), the interface moves to RESET (3) on the edge after the counter exceeds RESET_CYC. A low of RESET_CYC samples or fewer leaves the state unchanged.
- R2: `force_zero` and `req_ignore` are both 0 in NORMAL and both 1 in every other state.
- R3: On the edge after the low counter exceeds DISABLE_CYC, the interface moves to DISABLED (0). `sysclk_en` is 1 exactly in RESET, INIT and NORMAL.
- R4: While `rst_n` is low, the interface is DISABLED, `low_power` is 0, and the low counter is treated as saturated. Leaving DISABLED therefore needs a high sample of `link_pwr`.
- R5: From RESET, or from DISABLED when not in low-power mode, the edge after a high sample of `link_pwr` enters INIT. INIT lasts INIT_CYC cycles and then moves to NORMAL.
- R6: `low_power` rises only in DISABLED, and only after a sample in which every port was idle (not connected, or disabled, or suspended).
- R7: A port event clears `low_power` on the next edge and keeps it clear for WAKE_CYC further cycles. A port event is any of: bias rising on a suspended port, a suspended port disconnecting, or a connection appearing on a non-disabled port.
- R8: When `link_pwr` returns while `low_power` is 1, the interface passes through SETTLE (1) for SETTLE_CYC cycles before it enters INIT. If the low counter exceeds RESET_CYC during SETTLE, it returns to DISABLED.
- R9: After a high sample of `link_pwr` in low-power mode, `sysclk_en` rises within RESTART_MAX cycles, provided `link_pwr` stays high.
- R10: `cable_inactive` is 1 exactly when no bit of `port_bias` is set, combinationally and without filtering.
- R11: A high sample of `pwr_down` puts the block in the same state as a hardware reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on reference clock |
| rst_n | input | 1 | Asynchronous hardware reset, active low |
| pwr_down | input | 1 | Synchronous power-down, forces internal reset |
| link_pwr | input | 1 | Link power-status level from the link layer |
| port_conn | input | NPORT | Port has a cable connection |
| port_dis | input | NPORT | Port disabled |
| port_susp | input | NPORT | Port suspended |
| port_bias | input | NPORT | Port receives incoming bias |
| sysclk_en | output | 1 | System clock output enable |
| force_zero | output | 1 | Hold interface control and data outputs at zero |
| req_ignore | output | 1 | Ignore incoming link requests |
| cable_inactive | output | 1 | No port receives incoming bias |
| low_power | output | 1 | Device may enter low-power mode |
| if_state | output | 3 | 0 DISABLED, 1 SETTLE, 2 INIT, 3 RESET, 4 NORMAL |

## Verification
The hardest case to reach is the low-power window itself. The interface has to be driven through the long-low threshold into DISABLED with every port idle. Then a port event must arrive that clears low-power mode while the port stays idle, so that re-entry after the hold window can be seen. The directed part of the stimulus marks a port as suspended and connected at the same moment, which creates a connection event on a port that stays idle, and then raises bias on that suspended port. Random segments then mix short, mid and long lows with port changes and brief power-down pulses, and each cycle is compared against a bench model.

// File: rtl/lps_if_ctrl.sv
module lps_if_ctrl #(
  parameter int NPORT       = 2,
  parameter int RESET_CYC   = 63898,
  parameter int DISABLE_CYC = 638976,
  parameter int INIT_CYC    = 16,
  parameter int SETTLE_CYC  = 98304,
  parameter int WAKE_CYC    = 4096,
  parameter int RESTART_MAX = 179405
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             link_pwr,
  input  logic [NPORT-1:0] port_conn,
  input  logic [NPORT-1:0] port_dis,
  input  logic [NPORT-1:0] port_susp,
  input  logic [NPORT-1:0] port_bias,
  output logic             sysclk_en,
  output logic             force_zero,
  output logic             req_ignore,
  output logic             cable_inactive,
  output logic             low_power,
  output logic [2:0]       if_state
);
  localparam int LOW_MAX = DISABLE_CYC + 1;
  localparam int LW      = $clog2(LOW_MAX + 1);
  localparam int SEQ_MAX = (INIT_CYC > SETTLE_CYC) ? INIT_CYC : SETTLE_CYC;
  localparam int SW      = $clog2(SEQ_MAX + 1);
  localparam int HW      = $clog2(WAKE_CYC + 1);

  localparam logic [2:0] ST_DIS  = 3'd0;
  localparam logic [2:0] ST_SET  = 3'd1;
  localparam logic [2:0] ST_INIT = 3'd2;
  localparam logic [2:0] ST_RST  = 3'd3;
  localparam logic [2:0] ST_NORM = 3'd4;

  logic [2:0]       st, st_nx;
  logic [LW-1:0]    low_cnt;
  logic [SW-1:0]    seq_cnt;
  logic [HW-1:0]    hold;
  logic             lp;
  logic [NPORT-1:0] conn_q, bias_q, ev_vec, idle_vec;

  wire lps_seen   = (low_cnt == '0);
  wire short_gone = (low_cnt > LW'(RESET_CYC));
  wire long_gone  = (low_cnt > LW'(DISABLE_CYC));
  wire init_done  = (seq_cnt == SW'(INIT_CYC - 1));
  wire set_done   = (seq_cnt == SW'(SETTLE_CYC - 1));

  for (genvar i = 0; i < NPORT; i++) begin : g_port
    assign ev_vec[i] = (port_susp[i] & port_bias[i] & ~bias_q[i])
                     | (port_susp[i] & conn_q[i] & ~port_conn[i])
                     | (~port_dis[i] & port_conn[i] & ~conn_q[i]);
    assign idle_vec[i] = ~port_conn[i] | port_dis[i] | port_susp[i];
  end

  wire port_event = |ev_vec;
  wire all_idle   = &idle_vec;

  always_comb begin
    st_nx = st;
    case (st)
      ST_NORM: if (long_gone) st_nx = ST_DIS;
               else if (short_gone) st_nx = ST_RST;
      ST_RST:  if (long_gone) st_nx = ST_DIS;
               else if (lps_seen) st_nx = ST_INIT;
      ST_INIT: if (long_gone) st_nx = ST_DIS;
               else if (short_gone) st_nx = ST_RST;
               else if (init_done) st_nx = ST_NORM;
      ST_SET:  if (short_gone) st_nx = ST_DIS;
               else if (set_done) st_nx = ST_INIT;
      ST_DIS:  if (lps_seen) st_nx = lp ? ST_SET : ST_INIT;
      default: st_nx = ST_DIS;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st      <= ST_DIS;
      low_cnt <= LW'(LOW_MAX);
      seq_cnt <= '0;
      hold    <= '0;
      lp      <= 1'b0;
      conn_q  <= '0;
      bias_q  <= '0;
    end else if (pwr_down) begin
      st      <= ST_DIS;
      low_cnt <= LW'(LOW_MAX);
      seq_cnt <= '0;
      hold    <= '0;
      lp      <= 1'b0;
      conn_q  <= port_conn;
      bias_q  <= port_bias;
    end else begin
      st <= st_nx;
      if (st_nx != st)
        seq_cnt <= '0;
      else if (st == ST_INIT || st == ST_SET)
        seq_cnt <= seq_cnt + 1'b1;
      else
        seq_cnt <= '0;
      if (link_pwr)
        low_cnt <= '0;
      else if (low_cnt != LW'(LOW_MAX))
        low_cnt <= low_cnt + 1'b1;
      if (port_event)
        hold <= HW'(WAKE_CYC);
      else if (hold != '0)
        hold <= hold - 1'b1;
      lp     <= (st == ST_DIS) && all_idle && !lps_seen && (hold == '0) && !port_event;
      conn_q <= port_conn;
      bias_q <= port_bias;
    end
  end

  assign if_state       = st;
  assign sysclk_en      = (st == ST_RST) || (st == ST_INIT) || (st == ST_NORM);
  assign force_zero     = (st != ST_NORM);
  assign req_ignore     = (st != ST_NORM);
  assign low_power      = lp;
  assign cable_inactive = ~|port_bias;
endmodule

// File: rtl/lps_if_ctrl_chk.sv
module lps_if_ctrl_chk #(
  parameter int NPORT       = 2,
  parameter int DISABLE_CYC = 638976,
  parameter int RESTART_MAX = 179405
) (
  input logic             clk,
  input logic             rst_n,
  input logic             pwr_down,
  input logic             link_pwr,
  input logic [NPORT-1:0] port_conn,
  input logic [NPORT-1:0] port_dis,
  input logic [NPORT-1:0] port_susp,
  input logic             sysclk_en,
  input logic             force_zero,
  input logic             req_ignore,
  input logic             low_power,
  input logic [2:0]       if_state
);
  int unsigned low_run;
  int unsigned wait_cnt;
  wire idle_now = &(~port_conn | port_dis | port_susp);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_run  <= 0;
      wait_cnt <= 0;
    end else begin
      if (link_pwr) low_run <= 0;
      else if (low_run < DISABLE_CYC + 2) low_run <= low_run + 1;
      if (!link_pwr || sysclk_en || pwr_down) wait_cnt <= 0;
      else if (wait_cnt != 0 || low_power) wait_cnt <= wait_cnt + 1;
    end
  end

  p_clk_off_forces_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !sysclk_en |-> (force_zero && req_ignore));
  p_normal_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (if_state == 3'd4) |-> (!force_zero && !req_ignore));
  p_long_low_disables_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (low_run > DISABLE_CYC + 1) |-> (if_state == 3'd0 && !sysclk_en));
  p_lp_in_disabled_r6: assert property (@(posedge clk) disable iff (!rst_n)
    low_power |-> (if_state == 3'd0));
  p_lp_needs_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(low_power) |-> $past(idle_now));
  p_restart_deadline_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wait_cnt <= RESTART_MAX);
  p_pd_resets_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $past(pwr_down) |-> (if_state == 3'd0 && !low_power));
endmodule

bind lps_if_ctrl lps_if_ctrl_chk #(
  .NPORT(NPORT), .DISABLE_CYC(DISABLE_CYC), .RESTART_MAX(RESTART_MAX)
) u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .link_pwr(link_pwr),
  .port_conn(port_conn), .port_dis(port_dis), .port_susp(port_susp),
  .sysclk_en(sysclk_en), .force_zero(force_zero), .req_ignore(req_ignore),
  .low_power(low_power), .if_state(if_state)
);

// File: tb/sim_lps_if_ctrl.sv
module sim_lps_if_ctrl;
  localparam int NP = 2, RC = 20, DC = 60, IC = 5, SC = 12, WC = 8, RM = 20;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b1, pwr_down = 1'b0, link_pwr = 1'b0;
  logic [NP-1:0] port_conn = '0, port_dis = '0, port_susp = '0, port_bias = '0;
  logic sysclk_en, force_zero, req_ignore, cable_inactive, low_power;
  logic [2:0] if_state;

  lps_if_ctrl #(.NPORT(NP), .RESET_CYC(RC), .DISABLE_CYC(DC), .INIT_CYC(IC),
                .SETTLE_CYC(SC), .WAKE_CYC(WC), .RESTART_MAX(RM)) u0 (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down), .link_pwr(link_pwr),
    .port_conn(port_conn), .port_dis(port_dis), .port_susp(port_susp),
    .port_bias(port_bias), .sysclk_en(sysclk_en), .force_zero(force_zero),
    .req_ignore(req_ignore), .cable_inactive(cable_inactive),
    .low_power(low_power), .if_state(if_state));

  int checks = 0, errors = 0;
  bit cmp_on = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  int m_st, m_low, m_seq, m_hold;
  bit m_lp;
  logic [NP-1:0] m_pc, m_pb;

  function automatic bit f_event(logic [NP-1:0] pc, logic [NP-1:0] pb);
    bit e = 0;
    for (int i = 0; i < NP; i++)
      e |= (port_susp[i] & port_bias[i] & ~pb[i]) | (port_susp[i] & pc[i] & ~port_conn[i])
         | (~port_dis[i] & port_conn[i] & ~pc[i]);
    return e;
  endfunction

  function automatic bit f_idle();
    bit a = 1;
    for (int i = 0; i < NP; i++) a &= (~port_conn[i] | port_dis[i] | port_susp[i]);
    return a;
  endfunction

  function automatic int f_next(int st, int low, int seq, bit lp);
    bit sh = low > RC, lg = low > DC, seen = low == 0;
    case (st)
      4: return lg ? 0 : (sh ? 3 : 4);
      3: return lg ? 0 : (seen ? 2 : 3);
      2: return lg ? 0 : (sh ? 3 : (seq == IC - 1 ? 4 : 2));
      1: return sh ? 0 : (seq == SC - 1 ? 2 : 1);
      default: return seen ? (lp ? 1 : 2) : 0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st <= 0; m_low <= DC + 1; m_seq <= 0; m_hold <= 0; m_lp <= 0; m_pc <= '0; m_pb <= '0;
    end else if (pwr_down) begin
      m_st <= 0; m_low <= DC + 1; m_seq <= 0; m_hold <= 0; m_lp <= 0;
      m_pc <= port_conn; m_pb <= port_bias;
    end else begin
      int nx;
      bit ev;
      nx = f_next(m_st, m_low, m_seq, m_lp);
      ev = f_event(m_pc, m_pb);
      m_seq  <= (nx != m_st) ? 0 : ((m_st == 1 || m_st == 2) ? m_seq + 1 : 0);
      m_lp   <= (m_st == 0) && f_idle() && (m_low != 0) && (m_hold == 0) && !ev;
      m_hold <= ev ? WC : (m_hold != 0 ? m_hold - 1 : 0);
      m_low  <= link_pwr ? 0 : (m_low == DC + 1 ? m_low : m_low + 1);
      m_pc <= port_conn; m_pb <= port_bias; m_st <= nx;
    end
  end

  always @(posedge clk) begin
    #1;
    if (cmp_on) begin
      chk("R1 R3 R5 R8 if_state", int'(if_state), m_st);
      chk("R2 force_zero", int'(force_zero), int'(m_st != 4));
      chk("R2 req_ignore", int'(req_ignore), int'(m_st != 4));
      chk("R3 sysclk_en", int'(sysclk_en), int'(m_st >= 2));
      chk("R6 R7 low_power", int'(low_power), int'(m_lp));
      chk("R10 cable_inactive", int'(cable_inactive), int'(port_bias == '0));
    end
  end

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual timeout expected completion");
    summary();
  end

  task automatic perturb();
    if ($urandom % 16 == 0) begin
      int p = $urandom % NP;
      case ($urandom % 4)
        0: port_conn[p] = ~port_conn[p];
        1: port_dis[p]  = ~port_dis[p];
        2: port_susp[p] = ~port_susp[p];
        default: port_bias[p] = ~port_bias[p];
      endcase
    end
  endtask

  initial begin
    int n, st2;
    void'($urandom(32'd1394));
    #1 rst_n = 1'b0;
    cmp_on = 1'b1;
    repeat (3) @(negedge clk);
    chk("R4 reset if_state", int'(if_state), 0);
    chk("R4 reset sysclk_en", int'(sysclk_en), 0);
    chk("R4 reset force_zero", int'(force_zero), 1);
    chk("R4 reset low_power", int'(low_power), 0);
    rst_n = 1'b1; link_pwr = 1'b1;
    repeat (IC + SC + 6) @(negedge clk);
    chk("R5 reach normal", int'(if_state), 4);
    chk("R2 normal force_zero", int'(force_zero), 0);
    link_pwr = 1'b0;
    repeat (RC) @(negedge clk);
    link_pwr = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 short low ignored", int'(if_state), 4);
    link_pwr = 1'b0;
    repeat (RC + 2) @(negedge clk);
    chk("R1 enter reset", int'(if_state), 3);
    chk("R3 clock runs in reset", int'(sysclk_en), 1);
    chk("R2 ignore in reset", int'(req_ignore), 1);
    repeat (DC - RC + 2) @(negedge clk);
    chk("R3 enter disabled", int'(if_state), 0);
    chk("R3 clock stopped", int'(sysclk_en), 0);
    chk("R6 low power idle ports", int'(low_power), 1);
    port_susp[0] = 1'b1; port_conn[0] = 1'b1;
    @(negedge clk);
    chk("R7 event clears low power", int'(low_power), 0);
    repeat (WC) @(negedge clk);
    chk("R7 held after event", int'(low_power), 0);
    @(negedge clk);
    chk("R6 re-entry after hold", int'(low_power), 1);
    port_bias[0] = 1'b1;
    #1 chk("R10 bias seen", int'(cable_inactive), 0);
    @(negedge clk);
    chk("R7 bias event clears", int'(low_power), 0);
    repeat (WC + 3) @(negedge clk);
    chk("R6 low power again", int'(low_power), 1);
    link_pwr = 1'b1;
    n = 0; st2 = -1;
    while (!sysclk_en && n < 100) begin
      @(negedge clk);
      n++;
      if (n == 2) st2 = int'(if_state);
    end
    chk("R8 settle entered", st2, 1);
    chk("R9 restart within deadline", int'(n <= RM), 1);
    repeat (IC + 3) @(negedge clk);
    chk("R5 normal after restart", int'(if_state), 4);
    pwr_down = 1'b1;
    @(negedge clk);
    pwr_down = 1'b0;
    chk("R11 power-down state", int'(if_state), 0);
    chk("R11 power-down clock", int'(sysclk_en), 0);
    for (int s = 0; s < 500; s++) begin
      int len, hi;
      case ($urandom % 4)
        0: len = 1 + $urandom % RC;
        1: len = RC + 1 + $urandom % (DC - RC);
        2: len = DC + 2 + $urandom % 30;
        default: len = 0;
      endcase
      link_pwr = 1'b0;
      for (int k = 0; k < len; k++) begin @(negedge clk); perturb(); end
      link_pwr = 1'b1;
      hi = 1 + $urandom % 40;
      for (int k = 0; k < hi; k++) begin @(negedge clk); perturb(); end
      if ($urandom % 40 == 0) begin
        pwr_down = 1'b1;
        repeat (1 + $urandom % 3) @(negedge clk);
        pwr_down = 1'b0;
      end
    end
    summary();
  end
endmodule